// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block translates a 32-bit physical address into a destination. Software programs five decode windows through a simple word-addressed register port. Each window has an enable, a 4-bit target code, a size mask, a base and a remap value. The size, base and remap values count 64 KiB pages. The size register holds a run of ones starting at bit 0, so it is also the mask of the in-window page bits. A window that spans N pages has a size value of N-1.

On the lookup side, the caller presents an address with a valid strobe. One cycle later the block returns whether any enabled window matched, which window it was, that window's target code and the remapped address. Where windows overlap, the lowest-numbered enabled window decides the result. Target code 0 conventionally marks DRAM and code 2 marks PCIe. The decoder only passes the code through and does not interpret it.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled and every register reads zero. The result outputs are all zero.
- R2: `cfg_addr` is a word index. Bits [4:2] select the window, so window w starts at byte offset w*0x10. Bits [1:0] select the register: 0 control, 1 size, 2 base, 3 remap. Window indices 5 to 7 ignore writes and read as zero.
- R3: Control bit 0 is the enable and bits [7:4] are the target code. All other control bits read zero and ignore writes. Size, base and remap keep all 32 written bits and read them back unchanged.
- R4: A window whose enable bit is 0 never produces a hit, whatever its other registers hold.
- R5: An enabled window w matches when `(lk_addr[31:16] & ~size[15:0]) == (base[15:0] & ~size[15:0])`. Bits [31:16] of size, base and remap take no part in decoding.
- R6: When several enabled windows match, the result reports the lowest-numbered one, together with its target code in `res_target`.
- R7: On a hit, `res_addr[31:16]` is `(remap[15:0] & ~size[15:0]) | (lk_addr[31:16] & size[15:0])` and `res_addr[15:0]` equals `lk_addr[15:0]`.
- R8: On a miss, or when no lookup was issued, `res_hit`, `res_target`, `res_win` and `res_addr` are zero.
- R9: The result is registered. `res_valid` and the other result outputs reflect the `lk_valid`/`lk_addr` presented one cycle earlier.
- R10: A lookup issued in the same cycle as a register write uses the old register contents. A lookup issued in the following cycle uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word index (window, register) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Address to decode |
| res_valid | output | 1 | Result corresponds to a lookup of the previous cycle |
| res_hit | output | 1 | Some enabled window matched |
| res_target | output | 4 | Target code of the winning window |
| res_win | output | 3 | Index of the winning window |
| res_addr | output | 32 | Remapped address |

## Verification
The assertions are checked on every cycle. They cover the result-register timing against the lookup strobe and the all-zero result on a miss. They also cover the range of the reported window index, the pass-through of the page offset on a hit, and the zero read-back of the unused control bits. Other behaviour needs the full register contents and only the bench's scenarios can show it. This covers lowest-index priority among overlapping windows, the exact remap merge, disabled windows being skipped, writes to the missing window slots being dropped, and the write-versus-lookup ordering in a single cycle.

// File: rtl/awd_pkg.sv
package awd_pkg;
    parameter int NUM_WIN   = 5;
    parameter int ADDR_W    = 32;
    parameter int DATA_W    = 32;
    parameter int GRAN      = 16;
    parameter int TGT_W     = 4;
    parameter int TGT_LSB   = 4;
    parameter int WIN_IDX_W = $clog2(NUM_WIN);
    parameter int PAGE_W    = ADDR_W - GRAN;
    parameter int CFG_AW    = WIN_IDX_W + 2;

    typedef enum logic [1:0] {
        FLD_CTRL  = 2'd0,
        FLD_SIZE  = 2'd1,
        FLD_BASE  = 2'd2,
        FLD_REMAP = 2'd3
    } fld_e;

    typedef struct packed {
        logic              en;
        logic [TGT_W-1:0]  tgt;
        logic [DATA_W-1:0] size;
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] remap;
    } win_reg_t;

    typedef struct packed {
        logic              en;
        logic [PAGE_W-1:0] mask;
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] remap;
    } win_dec_t;

    typedef struct packed {
        logic                 valid;
        logic                 hit;
        logic [TGT_W-1:0]     tgt;
        logic [WIN_IDX_W-1:0] win;
        logic [ADDR_W-1:0]    addr;
    } result_t;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [CFG_AW-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output win_dec_t [NUM_WIN-1:0]        dec,
    output logic [NUM_WIN-1:0][TGT_W-1:0] tgt
);
    win_reg_t [NUM_WIN-1:0] regs_d, regs_q;
    logic [WIN_IDX_W-1:0]   sel;
    fld_e                   fld;
    logic                   sel_ok;

    assign sel    = addr[CFG_AW-1:2];
    assign fld    = fld_e'(addr[1:0]);
    assign sel_ok = (int'(sel) < NUM_WIN);

    always_comb begin
        regs_d = regs_q;
        rdata  = '0;
        if (sel_ok) begin
            if (we) begin
                unique case (fld)
                    FLD_CTRL: begin
                        regs_d[sel].en  = wdata[0];
                        regs_d[sel].tgt = wdata[TGT_LSB +: TGT_W];
                    end
                    FLD_SIZE:  regs_d[sel].size  = wdata;
                    FLD_BASE:  regs_d[sel].base  = wdata;
                    FLD_REMAP: regs_d[sel].remap = wdata;
                    default: ;
                endcase
            end
            unique case (fld)
                FLD_CTRL: begin
                    rdata[0]                = regs_q[sel].en;
                    rdata[TGT_LSB +: TGT_W] = regs_q[sel].tgt;
                end
                FLD_SIZE:  rdata = regs_q[sel].size;
                FLD_BASE:  rdata = regs_q[sel].base;
                FLD_REMAP: rdata = regs_q[sel].remap;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_out
        assign dec[w].en    = regs_q[w].en;
        assign dec[w].mask  = regs_q[w].size[PAGE_W-1:0];
        assign dec[w].base  = regs_q[w].base[PAGE_W-1:0];
        assign dec[w].remap = regs_q[w].remap[PAGE_W-1:0];
        assign tgt[w]       = regs_q[w].tgt;
    end
endmodule

// File: rtl/awd_match.sv
module awd_match
    import awd_pkg::*;
(
    input  win_dec_t [NUM_WIN-1:0]         dec,
    input  logic [PAGE_W-1:0]              page,
    output logic [NUM_WIN-1:0]             hit,
    output logic [NUM_WIN-1:0][PAGE_W-1:0] rpage
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign hit[w]   = dec[w].en &&
                          ((page & ~dec[w].mask) == (dec[w].base & ~dec[w].mask));
        assign rpage[w] = (dec[w].remap & ~dec[w].mask) | (page & dec[w].mask);
    end
endmodule

// File: rtl/awd_pick.sv
module awd_pick
    import awd_pkg::*;
(
    input  logic [NUM_WIN-1:0]   hit,
    output logic                 found,
    output logic [WIN_IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit[w]) begin
                found = 1'b1;
                idx   = WIN_IDX_W'(w);
            end
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import awd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 lk_valid,
    input  logic [ADDR_W-1:0]    lk_addr,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic [TGT_W-1:0]     res_target,
    output logic [WIN_IDX_W-1:0] res_win,
    output logic [ADDR_W-1:0]    res_addr
);
    win_dec_t [NUM_WIN-1:0]         dec;
    logic [NUM_WIN-1:0][TGT_W-1:0]  tgt;
    logic [NUM_WIN-1:0]             hit;
    logic [NUM_WIN-1:0][PAGE_W-1:0] rpage;
    logic                           found;
    logic [WIN_IDX_W-1:0]           idx;
    result_t                        res_d, res_q;

    awd_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .dec   (dec),
        .tgt   (tgt)
    );

    awd_match u_match (
        .dec   (dec),
        .page  (lk_addr[ADDR_W-1:GRAN]),
        .hit   (hit),
        .rpage (rpage)
    );

    awd_pick u_pick (
        .hit   (hit),
        .found (found),
        .idx   (idx)
    );

    always_comb begin
        res_d = '0;
        if (lk_valid) begin
            res_d.valid = 1'b1;
            if (found) begin
                res_d.hit  = 1'b1;
                res_d.win  = idx;
                res_d.tgt  = tgt[idx];
                res_d.addr = {rpage[idx], lk_addr[GRAN-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign res_hit    = res_q.hit;
    assign res_target = res_q.tgt;
    assign res_win    = res_q.win;
    assign res_addr   = res_q.addr;
endmodule

// File: rtl/awd_checker.sv
module awd_checker
    import awd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [CFG_AW-1:0]    cfg_addr,
    input logic [DATA_W-1:0]    cfg_wdata,
    input logic [DATA_W-1:0]    cfg_rdata,
    input logic                 lk_valid,
    input logic [ADDR_W-1:0]    lk_addr,
    input logic                 res_valid,
    input logic                 res_hit,
    input logic [TGT_W-1:0]     res_target,
    input logic [WIN_IDX_W-1:0] res_win,
    input logic [ADDR_W-1:0]    res_addr
);
    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_valid == $past(lk_valid)));

    // R9
    hit_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_target == '0 && res_win == '0 && res_addr == '0));

    // R6
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (int'(res_win) < NUM_WIN));

    // R7
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_hit) |-> (res_addr[GRAN-1:0] == $past(lk_addr[GRAN-1:0])));

    // R3
    ctrl_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr[1:0] == 2'd0) |->
            (cfg_rdata[DATA_W-1:TGT_LSB+TGT_W] == '0 && cfg_rdata[TGT_LSB-1:1] == '0));
endmodule

bind addr_window_decoder awd_checker chk_i (.*);

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic        res_valid, res_hit;
    logic [3:0]  res_target;
    logic [2:0]  res_win;
    logic [31:0] res_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int unsigned seed = 32'h1234_abcd;

    logic [31:0] m_ctrl[5], m_size[5], m_base[5], m_remap[5];

    always #5 clk = ~clk;

    addr_window_decoder dut_i (.*);

    function automatic logic [31:0] m_read(input logic [4:0] wa);
        int w = int'(wa[4:2]);
        if (w >= 5) return 32'h0;
        case (wa[1:0])
            2'd0:    return m_ctrl[w];
            2'd1:    return m_size[w];
            2'd2:    return m_base[w];
            default: return m_remap[w];
        endcase
    endfunction

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, check read data, model the lookup, check result after edge
    task automatic cyc(input bit we, input logic [4:0] wa, input logic [31:0] wd,
                       input bit lv, input logic [31:0] la, input string tag);
        bit          e_hit = 0;
        logic [3:0]  e_tgt = 0;
        logic [2:0]  e_win = 0;
        logic [31:0] e_addr = 0;
        @(negedge clk);
        cfg_we = we; cfg_addr = wa; cfg_wdata = wd; lk_valid = lv; lk_addr = la;
        #1;
        check(tag, "rdata", {32'h0, cfg_rdata}, {32'h0, m_read(wa)});
        if (lv) begin
            for (int w = 0; w < 5; w++) begin
                logic [15:0] mk = m_size[w][15:0];
                if (!e_hit && m_ctrl[w][0] &&
                    ((la[31:16] & ~mk) == (m_base[w][15:0] & ~mk))) begin
                    e_hit  = 1;
                    e_win  = 3'(w);
                    e_tgt  = m_ctrl[w][7:4];
                    e_addr = {(m_remap[w][15:0] & ~mk) | (la[31:16] & mk), la[15:0]};
                end
            end
        end
        if (we && wa[4:2] < 3'd5) begin
            case (wa[1:0])
                2'd0: m_ctrl[wa[4:2]]  = wd & 32'h0000_00f1;
                2'd1: m_size[wa[4:2]]  = wd;
                2'd2: m_base[wa[4:2]]  = wd;
                default: m_remap[wa[4:2]] = wd;
            endcase
        end
        @(posedge clk);
        #1;
        check(tag, "result", {22'h0, res_valid, res_hit, res_target, res_win, res_addr},
                             {22'h0, lv, e_hit, e_tgt, e_win, e_addr});
    endtask

    task automatic wr(input int w, input int f, input logic [31:0] d, input string tag);
        cyc(1, {3'(w), 2'(f)}, d, 0, 32'h0, tag);
    endtask

    initial begin
        for (int w = 0; w < 5; w++) begin
            m_ctrl[w] = 0; m_size[w] = 0; m_base[w] = 0; m_remap[w] = 0;
        end
        rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; lk_valid = 0; lk_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R1: reset state of result outputs
        check("R1", "reset result", {27'h0, res_valid, res_hit, res_target, res_win},
              64'h0);
        check("R1", "reset addr", {32'h0, res_addr}, 64'h0);
        // R1: every register reads zero, lookups miss
        for (int a = 0; a < 32; a++) cyc(0, 5'(a), 0, 1, 32'(a) << 27, "R1");

        // R5 R7: DRAM window 0 (1 GiB at 0), PCIe window 1 at 0xE800_0000 remapped
        wr(0, 1, 32'h0000_3fff, "R3");
        wr(0, 0, 32'h0000_0001, "R3");
        wr(1, 1, 32'h0000_00ff, "R3");
        wr(1, 2, 32'h0000_e800, "R3");
        wr(1, 3, 32'hdead_1200, "R3");
        wr(1, 0, 32'h0000_0021, "R3");
        cyc(0, 5'd0, 0, 1, 32'h1234_5678, "R5");
        cyc(0, 5'd4, 0, 1, 32'he812_3456, "R7");
        cyc(0, 5'd7, 0, 1, 32'he8ff_ffff, "R7");
        cyc(0, 5'd6, 0, 1, 32'he900_0000, "R8");
        cyc(0, 5'd0, 0, 1, 32'h8000_0000, "R8");
        // R9: no lookup means no valid result
        cyc(0, 5'd0, 0, 0, 32'h1234_5678, "R9");

        // R3: spare control bits dropped, data registers keep all bits
        wr(2, 0, 32'hffff_ff0e, "R3");
        cyc(0, 5'd8, 0, 0, 0, "R3");
        wr(2, 0, 32'hffff_ffff, "R3");
        cyc(0, 5'd8, 0, 1, 32'h0000_1234, "R6");
        cyc(0, 5'd7, 0, 0, 0, "R3");

        // R4: window 3 covers everything but is disabled
        wr(3, 1, 32'h0000_ffff, "R4");
        wr(3, 0, 32'h0000_0030, "R4");
        cyc(0, 5'd12, 0, 1, 32'h8000_0000, "R4");
        cyc(0, 5'd13, 0, 1, 32'hc000_0010, "R4");
        // R6: enable it, lower windows still win where they overlap
        wr(3, 0, 32'h0000_0031, "R6");
        cyc(0, 5'd12, 0, 1, 32'h8000_0000, "R6");
        cyc(0, 5'd12, 0, 1, 32'h1000_0000, "R6");
        cyc(0, 5'd12, 0, 1, 32'he800_0004, "R6");
        wr(3, 0, 32'h0, "R4");

        // R10: write enable of window 4 in the same cycle as a lookup into it
        wr(4, 1, 32'h0000_000f, "R10");
        wr(4, 2, 32'h0000_4000, "R10");
        cyc(1, 5'd16, 32'h0000_0041, 1, 32'h4003_0000, "R10");
        cyc(0, 5'd16, 0, 1, 32'h4003_0000, "R10");

        // R2: slots of windows 5..7 ignore writes and read zero
        for (int a = 20; a < 32; a++) cyc(1, 5'(a), 32'hffff_ffff, 1, 32'h4001_0000, "R2");
        for (int a = 0; a < 32; a++) cyc(0, 5'(a), 0, 1, 32'he800_0000, "R2");

        // R5: mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int unsigned r1 = rnd();
            int unsigned r2 = rnd();
            int unsigned r3 = rnd();
            logic [31:0] wd = r2;
            if (r1[1:0] == 2'd1) wd = (32'h1 << r2[3:0]) - 1;
            cyc(r1[5:4] == 2'd0, 5'(r1 >> 8), wd, r1[20], r3, "R5");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule